// File: doc/BRIEF.md
# Critical-Word-First Line Fill Engine

This block services one cache load miss at a time. It takes the physical byte address of the missing load, and it sends a single burst request for the whole line to the next memory level. The request names the line and also the chunk that holds the demanded word, so the next level starts the burst with that chunk. The next level then returns the other chunks in wrap-around order. The block does not do any address translation, because the address it receives is already physical.

The first beat of the burst goes straight to the load pipeline as a restart. The pipeline can therefore resume without waiting for the remaining beats. At the same time, every beat is written into a line buffer at the chunk slot it belongs to. When the last chunk has arrived, the finished line goes to the data array in one write, and that write also marks the line valid. A second miss is held off until the fill is complete. A build parameter can delay the restart by one register stage.

Top module: `cwf_line_fill`

## Requirements
- R1: While reset is held low, `miss_ready` is 1 and `mem_req_valid`, `restart_valid` and `arr_wr_en` are all 0.
- R2: In the cycle after a miss is accepted (`miss_valid` and `miss_ready` both high at a clock edge), `mem_req_valid` is 1. `mem_req_line_addr` then equals `miss_addr[31:6]` and `mem_req_first` equals `miss_addr[5:3]`. All three stay unchanged until `mem_req_ready` is seen high, and `mem_req_valid` drops in the cycle after that.
- R3: With the default restart latency of zero, `restart_valid` is 1 in the same cycle as the first accepted response beat of a fill, and `restart_data` then equals `mem_rsp_data`. `restart_valid` is high for exactly one cycle per fill.
- R4: The k-th accepted response beat (k counted from 0) is stored in chunk slot `(mem_req_first + k) mod 8`. Chunk slot i occupies bits `[64*i+63 : 64*i]` of `arr_wr_line`. A start at slot 7 wraps to slot 0 as its second beat.
- R5: `arr_wr_en` is a single-cycle pulse in the cycle after the eighth beat is accepted, and never earlier. During that pulse `arr_wr_addr` holds the line address of the miss and `arr_wr_line` holds all eight chunks. The pulse both writes the line and marks it valid.
- R6: From the accepting edge until the commit cycle ends, `miss_ready` is 0, and any `miss_valid` raised in that window starts nothing. After the commit, the block is idle with `miss_ready` at 1 and `mem_req_valid` at 0.
- R7: A cycle with `mem_rsp_valid` low during a fill does not count as a beat. It does not advance the slot order, does not raise `restart_valid` and does not hasten the commit.
- R8: `mem_rsp_valid` pulses while no fill is waiting for data are ignored. They cause no restart, no commit and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load miss is offered |
| miss_addr | input | 32 | Physical byte address of the missing load |
| miss_ready | output | 1 | Block is idle and accepts a miss |
| mem_req_valid | output | 1 | Line request to the next level |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_line_addr | output | 26 | Line address of the request |
| mem_req_first | output | 3 | Chunk slot the burst must start with |
| mem_rsp_valid | input | 1 | A response beat is present |
| mem_rsp_data | input | 64 | Response beat data |
| restart_valid | output | 1 | Demanded chunk is presented to the load pipeline |
| restart_data | output | 64 | Chunk holding the demanded word |
| arr_wr_en | output | 1 | Write the line into the data array and set its valid bit |
| arr_wr_addr | output | 26 | Line address of the array write |
| arr_wr_line | output | 512 | Complete assembled line |

## Verification
- **Request:** the request appears one cycle after the accepting edge.
- **Restart:** the restart flag and data follow the first beat within the same cycle, with no register on the path.
- **Commit:** the array write comes exactly one cycle after the eighth accepted beat and lasts one cycle.

**How the bench keeps to these cycles:** it changes inputs on the falling edge. It checks the combinational results (restart, request fields, readiness) one nanosecond later, inside the cycle the beat occupies. It checks registered results (request, commit) after the rising edge that produces them. The cycle after the commit is checked as well, to show that the pulse has ended.

**Scenarios covered:** fills that start at slots 0, 3, 5 and 7, with and without gaps between beats, with a stalled request, and with a competing miss held high during a fill.

// File: rtl/cwf_fill_pkg.sv
package cwf_fill_pkg;

   typedef enum logic [1:0] {
      FS_IDLE   = 2'd0,
      FS_REQ    = 2'd1,
      FS_FILL   = 2'd2,
      FS_COMMIT = 2'd3
   } fill_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
   import cwf_fill_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CHUNKS      = 8,
   parameter int CHUNK_OFF_W = 3,
   parameter int IDX_W       = 3,
   parameter int LADDR_W     = 26
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               miss_valid,
   input  logic [ADDR_W-1:0]  miss_addr,
   output logic               miss_ready,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [LADDR_W-1:0] mem_req_line_addr,
   output logic [IDX_W-1:0]   mem_req_first,
   input  logic               mem_rsp_valid,
   output logic               beat_take,
   output logic               beat_is_first,
   output logic [IDX_W-1:0]   beat_idx,
   output logic               commit_en,
   output logic [LADDR_W-1:0] commit_line_addr
);

   localparam int LINE_OFF_W = CHUNK_OFF_W + IDX_W;
   localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(CHUNKS - 1);

   fill_state_e        state_q, state_d;
   logic [LADDR_W-1:0] line_q;
   logic [IDX_W-1:0]   first_q;
   logic [IDX_W-1:0]   cnt_q;
   logic               miss_take;
   logic               last_beat;
   logic               unused_byte_sel;

   assign unused_byte_sel = ^miss_addr[CHUNK_OFF_W-1:0];

   assign miss_ready    = (state_q == FS_IDLE);
   assign miss_take     = miss_ready && miss_valid;
   assign mem_req_valid = (state_q == FS_REQ);
   assign beat_take     = (state_q == FS_FILL) && mem_rsp_valid;
   assign beat_is_first = beat_take && (cnt_q == '0);
   assign last_beat     = (cnt_q == LAST_BEAT);
   assign commit_en     = (state_q == FS_COMMIT);

   // slot index wraps naturally because CHUNKS is a power of two
   assign beat_idx = first_q + cnt_q;

   assign mem_req_line_addr = line_q;
   assign mem_req_first     = first_q;
   assign commit_line_addr  = line_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         FS_IDLE:   if (miss_valid)              state_d = FS_REQ;
         FS_REQ:    if (mem_req_ready)           state_d = FS_FILL;
         FS_FILL:   if (beat_take && last_beat)  state_d = FS_COMMIT;
         FS_COMMIT:                              state_d = FS_IDLE;
         default:                                state_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         line_q  <= '0;
         first_q <= '0;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (miss_take) begin
            line_q  <= miss_addr[ADDR_W-1:LINE_OFF_W];
            first_q <= miss_addr[LINE_OFF_W-1:CHUNK_OFF_W];
         end
         if (state_q == FS_REQ)
            cnt_q <= '0;
         else if (beat_take)
            cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
   parameter int CHUNK_W = 64,
   parameter int CHUNKS  = 8,
   parameter int IDX_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [CHUNK_W-1:0]        wr_data,
   output logic [CHUNK_W*CHUNKS-1:0] line
);

   for (genvar i = 0; i < CHUNKS; i++) begin : g_slot
      logic [CHUNK_W-1:0] slot_q;
      logic               hit;

      assign hit = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q <= '0;
         else if (hit)
            slot_q <= wr_data;
      end

      assign line[i*CHUNK_W +: CHUNK_W] = slot_q;
   end

endmodule

// File: rtl/cwf_restart_fwd.sv
module cwf_restart_fwd #(
   parameter int CHUNK_W     = 64,
   parameter int RESTART_LAT = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               first_beat,
   input  logic [CHUNK_W-1:0] beat_data,
   output logic               restart_valid,
   output logic [CHUNK_W-1:0] restart_data
);

   if (RESTART_LAT == 0) begin : g_bypass
      logic unused_clk;
      assign unused_clk    = clk ^ rst_n;
      assign restart_valid = first_beat;
      assign restart_data  = beat_data;
   end else begin : g_staged
      logic               v_q;
      logic [CHUNK_W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else begin
            v_q <= first_beat;
            if (first_beat) d_q <= beat_data;
         end
      end
      assign restart_valid = v_q;
      assign restart_data  = d_q;
   end

endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
   import cwf_fill_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CHUNK_W     = 64,
   parameter int CHUNKS      = 8,
   parameter int RESTART_LAT = 0,
   localparam int CHUNK_OFF_W = $clog2(CHUNK_W / 8),
   localparam int IDX_W       = $clog2(CHUNKS),
   localparam int LINE_OFF_W  = CHUNK_OFF_W + IDX_W,
   localparam int LADDR_W     = ADDR_W - LINE_OFF_W,
   localparam int LINE_W      = CHUNK_W * CHUNKS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               miss_valid,
   input  logic [ADDR_W-1:0]  miss_addr,
   output logic               miss_ready,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [LADDR_W-1:0] mem_req_line_addr,
   output logic [IDX_W-1:0]   mem_req_first,
   input  logic               mem_rsp_valid,
   input  logic [CHUNK_W-1:0] mem_rsp_data,
   output logic               restart_valid,
   output logic [CHUNK_W-1:0] restart_data,
   output logic               arr_wr_en,
   output logic [LADDR_W-1:0] arr_wr_addr,
   output logic [LINE_W-1:0]  arr_wr_line
);

   if (!is_pow2(CHUNK_W) || CHUNK_W < 8) begin : g_bad_chunk
      $error("chunk width must be a power of two of at least 8 bits");
   end
   if (!is_pow2(CHUNKS) || CHUNKS < 2) begin : g_bad_count
      $error("chunk count must be a power of two of at least 2");
   end
   if (LADDR_W < 1) begin : g_bad_addr
      $error("address too narrow for one line");
   end
   if (RESTART_LAT != 0 && RESTART_LAT != 1) begin : g_bad_lat
      $error("restart latency must be 0 or 1");
   end

   logic             beat_take;
   logic             beat_is_first;
   logic [IDX_W-1:0] beat_idx;

   cwf_fill_ctrl #(
      .ADDR_W      (ADDR_W),
      .CHUNKS      (CHUNKS),
      .CHUNK_OFF_W (CHUNK_OFF_W),
      .IDX_W       (IDX_W),
      .LADDR_W     (LADDR_W)
   ) u_ctrl (
      .clk               (clk),
      .rst_n             (rst_n),
      .miss_valid        (miss_valid),
      .miss_addr         (miss_addr),
      .miss_ready        (miss_ready),
      .mem_req_valid     (mem_req_valid),
      .mem_req_ready     (mem_req_ready),
      .mem_req_line_addr (mem_req_line_addr),
      .mem_req_first     (mem_req_first),
      .mem_rsp_valid     (mem_rsp_valid),
      .beat_take         (beat_take),
      .beat_is_first     (beat_is_first),
      .beat_idx          (beat_idx),
      .commit_en         (arr_wr_en),
      .commit_line_addr  (arr_wr_addr)
   );

   cwf_line_buf #(
      .CHUNK_W (CHUNK_W),
      .CHUNKS  (CHUNKS),
      .IDX_W   (IDX_W)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (beat_take),
      .wr_idx  (beat_idx),
      .wr_data (mem_rsp_data),
      .line    (arr_wr_line)
   );

   cwf_restart_fwd #(
      .CHUNK_W     (CHUNK_W),
      .RESTART_LAT (RESTART_LAT)
   ) u_fwd (
      .clk           (clk),
      .rst_n         (rst_n),
      .first_beat    (beat_is_first),
      .beat_data     (mem_rsp_data),
      .restart_valid (restart_valid),
      .restart_data  (restart_data)
   );

endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
   parameter int CHUNKS      = 8,
   parameter int IDX_W       = 3,
   parameter int LADDR_W     = 26,
   parameter int RESTART_LAT = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               miss_ready,
   input logic               mem_req_valid,
   input logic               mem_req_ready,
   input logic [LADDR_W-1:0] mem_req_line_addr,
   input logic [IDX_W-1:0]   mem_req_first,
   input logic               mem_rsp_valid,
   input logic               restart_valid,
   input logic               arr_wr_en
);

   localparam int CW = $clog2(CHUNKS + 1);

   logic          in_fill;
   logic [CW-1:0] beats;
   logic          seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_fill <= 1'b0;
         beats   <= '0;
         seen    <= 1'b0;
      end else begin
         if (mem_req_valid && mem_req_ready) begin
            in_fill <= 1'b1;
            beats   <= '0;
         end else if (in_fill && mem_rsp_valid) begin
            beats <= beats + 1'b1;
            if (beats == CW'(CHUNKS - 1)) in_fill <= 1'b0;
         end
         if (restart_valid)  seen <= 1'b1;
         else if (arr_wr_en) seen <= 1'b0;
      end
   end

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid
         && $stable(mem_req_line_addr) && $stable(mem_req_first));

   assert_restart_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart_valid |-> !seen);

   assert_commit_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_en |-> (beats == CW'(CHUNKS)) && !in_fill);

   assert_commit_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_en |=> !arr_wr_en);

   assert_busy_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !miss_ready);

   assert_busy_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fill || arr_wr_en) |-> !miss_ready);

   if (RESTART_LAT == 0) begin : g_direct
      assert_restart_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
         restart_valid |-> in_fill && mem_rsp_valid && (beats == '0));
   end

endmodule

bind cwf_line_fill cwf_line_fill_chk #(
   .CHUNKS      (CHUNKS),
   .IDX_W       (IDX_W),
   .LADDR_W     (LADDR_W),
   .RESTART_LAT (RESTART_LAT)
) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .miss_ready        (miss_ready),
   .mem_req_valid     (mem_req_valid),
   .mem_req_ready     (mem_req_ready),
   .mem_req_line_addr (mem_req_line_addr),
   .mem_req_first     (mem_req_first),
   .mem_rsp_valid     (mem_rsp_valid),
   .restart_valid     (restart_valid),
   .arr_wr_en         (arr_wr_en)
);

// File: tb/cwf_line_fill_tb.sv
`timescale 1ns/100ps
module cwf_line_fill_tb;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         miss_valid;
   logic [31:0]  miss_addr;
   logic         miss_ready;
   logic         mem_req_valid;
   logic         mem_req_ready;
   logic [25:0]  mem_req_line_addr;
   logic [2:0]   mem_req_first;
   logic         mem_rsp_valid;
   logic [63:0]  mem_rsp_data;
   logic         restart_valid;
   logic [63:0]  restart_data;
   logic         arr_wr_en;
   logic [25:0]  arr_wr_addr;
   logic [511:0] arr_wr_line;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   cwf_line_fill u_dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .miss_valid        (miss_valid),
      .miss_addr         (miss_addr),
      .miss_ready        (miss_ready),
      .mem_req_valid     (mem_req_valid),
      .mem_req_ready     (mem_req_ready),
      .mem_req_line_addr (mem_req_line_addr),
      .mem_req_first     (mem_req_first),
      .mem_rsp_valid     (mem_rsp_valid),
      .mem_rsp_data      (mem_rsp_data),
      .restart_valid     (restart_valid),
      .restart_data      (restart_data),
      .arr_wr_en         (arr_wr_en),
      .arr_wr_addr       (arr_wr_addr),
      .arr_wr_line       (arr_wr_line)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [511:0] act, input logic [511:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] beat_data(input logic [31:0] seed, input int idx);
      return {seed, 16'hBEEF, 13'h0, 3'(idx)};
   endfunction

   task automatic t_reset();
      rst_n = 1'b0; miss_valid = 1'b0; miss_addr = '0;
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      repeat (3) @(negedge clk);
      #1;
      chk(miss_ready == 1'b1, "R1 miss_ready", 512'(miss_ready), 512'd1);
      chk({mem_req_valid, restart_valid, arr_wr_en} == 3'b000, "R1 outputs idle",
          512'({mem_req_valid, restart_valid, arr_wr_en}), 512'd0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_idle_rsp();
      @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 64'hDEAD_0000_0000_0001;
      for (int c = 0; c < 3; c++) begin
         #1;
         chk({restart_valid, arr_wr_en, mem_req_valid} == 3'b000, "R8 stray beat ignored",
             512'({restart_valid, arr_wr_en, mem_req_valid}), 512'd0);
         @(negedge clk);
      end
      mem_rsp_valid = 1'b0;
   endtask

   task automatic t_fill(input logic [31:0] addr, input logic [31:0] seed,
                         input bit gaps, input bit stall, input bit poke);
      logic [2:0]   first;
      logic [511:0] exp_line;
      first = addr[5:3];
      for (int i = 0; i < 8; i++) exp_line[i*64 +: 64] = beat_data(seed, i);

      @(negedge clk);
      #1;
      chk(miss_ready == 1'b1, "R6 idle before miss", 512'(miss_ready), 512'd1);
      miss_valid = 1'b1;
      miss_addr  = addr;
      @(negedge clk);
      miss_valid = 1'b0;
      #1;
      chk(mem_req_valid == 1'b1, "R2 request raised", 512'(mem_req_valid), 512'd1);
      chk(mem_req_line_addr == addr[31:6], "R2 line address",
          512'(mem_req_line_addr), 512'(addr[31:6]));
      chk(mem_req_first == first, "R2 first chunk", 512'(mem_req_first), 512'(first));
      chk(miss_ready == 1'b0, "R6 busy after accept", 512'(miss_ready), 512'd0);
      if (poke) begin
         miss_valid = 1'b1;
         miss_addr  = addr ^ 32'h1000_0040;
      end
      if (stall) begin
         for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            #1;
            chk(mem_req_valid && mem_req_line_addr == addr[31:6] && mem_req_first == first,
                "R2 request held", 512'({mem_req_valid, mem_req_line_addr, mem_req_first}),
                512'({1'b1, addr[31:6], first}));
         end
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      #1;
      chk(mem_req_valid == 1'b0, "R2 request dropped", 512'(mem_req_valid), 512'd0);

      for (int k = 0; k < 8; k++) begin
         if (gaps && (k % 3 == 1)) begin
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 64'hFFFF_FFFF_FFFF_FFFF;
            #1;
            chk({restart_valid, arr_wr_en} == 2'b00, "R7 gap is no beat",
                512'({restart_valid, arr_wr_en}), 512'd0);
            @(negedge clk);
         end
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = beat_data(seed, (int'(first) + k) % 8);
         #1;
         chk(restart_valid == (k == 0), "R3 restart on first beat only",
             512'(restart_valid), 512'(k == 0));
         if (k == 0)
            chk(restart_data == mem_rsp_data, "R3 restart data",
                512'(restart_data), 512'(mem_rsp_data));
         chk(arr_wr_en == 1'b0, "R5 no early commit", 512'(arr_wr_en), 512'd0);
         if (poke)
            chk(miss_ready == 1'b0, "R6 busy during fill", 512'(miss_ready), 512'd0);
         @(negedge clk);
      end
      mem_rsp_valid = 1'b0;
      miss_valid    = 1'b0;
      #1;
      chk(arr_wr_en == 1'b1, "R5 commit pulse", 512'(arr_wr_en), 512'd1);
      chk(arr_wr_addr == addr[31:6], "R5 commit address",
          512'(arr_wr_addr), 512'(addr[31:6]));
      chk(arr_wr_line == exp_line, "R4 wrapped placement", arr_wr_line, exp_line);
      @(negedge clk);
      #1;
      chk(arr_wr_en == 1'b0, "R5 single pulse", 512'(arr_wr_en), 512'd0);
      chk(miss_ready == 1'b1 && mem_req_valid == 1'b0, "R6 idle after commit",
          512'({miss_ready, mem_req_valid}), 512'b10);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_idle_rsp();
      t_fill(32'h0000_1000, 32'hA000_0001, 1'b0, 1'b0, 1'b0); // start slot 0
      t_fill(32'h0040_2238, 32'hA000_0002, 1'b1, 1'b0, 1'b0); // start slot 7, wraps
      t_fill(32'h1234_5658, 32'hA000_0003, 1'b0, 1'b1, 1'b1); // slot 3, stalled, poked
      t_idle_rsp();
      t_fill(32'hFFFF_FFEC, 32'hA000_0004, 1'b1, 1'b1, 1'b0); // slot 5
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule